// File: doc/BRIEF.md
# Hot-Plug-Detect Pulse Controller

This block drives the hot-plug-detect lines of a multi-port video input switch. Each line is open drain. At rest the block releases every line. When the selected input channel changes, it pulls every line low for a programmed number of milliseconds, so the attached sources see a disconnect and read the sink's capabilities again. The pulse length is kept in a width register in units of 20 ms. The reset value of that register gives 120 ms.

A host can take any line out of automatic control through an override register. That register holds one enable bit and one level bit for each port. A start-up hold input, driven by the capability-copy sequencer, forces every line low while it is asserted. This hold wins over both the override and the pulse. Time is measured by counting single-cycle pulses on a millisecond timebase input. The block has no clock divider of its own.

Top module: `hpd_pulse_ctrl`

## Requirements
- R1: After reset no line is pulled low, the width register holds 6 (120 ms), the override register holds 0 and the stored channel is 0. With the channel unchanged, no millisecond tick pulls any line low.
- R2: A value on `chan_sel` that differs from the stored channel, sampled at a clock edge, makes every `hpd_pull_low` bit read 1 from that edge on. This holds when the width register is non-zero.
- R3: The pulse lasts for width×20 `ms_tick` pulses. The lines are released after the edge that samples the last tick. Edges without a tick do not shorten the pulse.
- R4: A write with `cfg_wr_en`=1 to address 0x5 loads the width register from `cfg_wdata`. A write to address 0x6 loads the override register: bits 3:0 are the per-port enables and bits 7:4 are the per-port levels (1 = released, 0 = pulled low). Writes to any other address are ignored.
- R5: A channel change during an active pulse restarts the pulse at the full programmed length.
- R6: A channel change while the width register is 0 produces no pulse.
- R7: When port i's enable bit is set, its line is pulled low exactly when its level bit is 0, whatever the pulse state. Ports with a clear enable bit follow the automatic pulse.
- R8: While `hold_all` is 1, every line is pulled low in the same cycle, regardless of the override or the pulse.
- R9: Writing the width register during an active pulse does not change the length of that pulse. The new value applies from the next channel change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_sel | input | 2 | Selected input channel |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| hold_all | input | 1 | Start-up hold; forces all lines low |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| hpd_pull_low | output | 4 | Per-port open-drain enable, 1 = drive line low |

## Verification
A channel change and a register write each take effect at the first clock edge that samples them. Their results are due one cycle later. The bench therefore drives inputs on the falling edge and samples on the following falling edge. The end of a pulse is due on the edge that samples the final tick, so the bench checks that the lines are still low after one tick fewer than the programmed count, and released after one more. The hold input acts in the same cycle, so it is checked one time unit after it is driven, with no clock edge in between.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
  // Pulse length in millisecond ticks for a width code.
  function automatic int unsigned pulse_len(input int unsigned width_code,
                                            input int unsigned step_ms);
    return width_code * step_ms;
  endfunction

  // Counter width able to hold the longest pulse.
  function automatic int unsigned cnt_bits(input int unsigned dw,
                                           input int unsigned step_ms);
    return $clog2(((2 ** dw) - 1) * step_ms + 1);
  endfunction
endpackage

// File: rtl/hpd_chan_watch.sv
module hpd_chan_watch #(
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SELW-1:0] chan_sel,
  output logic            sw_event
);
  logic [SELW-1:0] chan_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chan_q <= '0;
    else        chan_q <= chan_sel;
  end

  assign sw_event = (chan_sel != chan_q);
endmodule

// File: rtl/hpd_regs.sv
module hpd_regs #(
  parameter int          NPORT    = 4,
  parameter int          ADDRW    = 4,
  parameter int          DW       = 8,
  parameter int unsigned PW_RESET = 6,
  parameter int unsigned ADDR_PW  = 5,
  parameter int unsigned ADDR_OVR = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ADDRW-1:0] addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    width_q,
  output logic [NPORT-1:0] ovr_en,
  output logic [NPORT-1:0] ovr_lvl
);
  localparam logic [ADDRW-1:0] A_PW  = ADDR_PW[ADDRW-1:0];
  localparam logic [ADDRW-1:0] A_OVR = ADDR_OVR[ADDRW-1:0];

  logic hit_pw, hit_ovr;
  assign hit_pw  = wr_en && (addr == A_PW);
  assign hit_ovr = wr_en && (addr == A_OVR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= PW_RESET[DW-1:0];
      ovr_en  <= '0;
      ovr_lvl <= '0;
    end else begin
      if (hit_pw) width_q <= wdata;
      if (hit_ovr) begin
        ovr_en  <= wdata[NPORT-1:0];
        ovr_lvl <= wdata[2*NPORT-1:NPORT];
      end
    end
  end
endmodule

// File: rtl/hpd_pulse_timer.sv
module hpd_pulse_timer #(
  parameter int DW      = 8,
  parameter int STEP_MS = 20,
  parameter int CNTW    = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DW-1:0]   width,
  input  logic            ms_tick,
  output logic            active,
  output logic [CNTW-1:0] remaining
);
  import hpd_pkg::*;

  logic [CNTW-1:0] load_len;
  assign load_len = CNTW'(pulse_len(32'(width), 32'(STEP_MS)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      remaining <= '0;
    end else if (start) begin
      active    <= (load_len != '0);
      remaining <= load_len;
    end else if (active && ms_tick) begin
      if (remaining == CNTW'(1)) active <= 1'b0;
      remaining <= remaining - CNTW'(1);
    end
  end
endmodule

// File: rtl/hpd_pulse_ctrl.sv
module hpd_pulse_ctrl #(
  parameter int          NPORT    = 4,
  parameter int          SELW     = 2,
  parameter int          ADDRW    = 4,
  parameter int          DW       = 8,
  parameter int          STEP_MS  = 20,
  parameter int unsigned PW_RESET = 6,
  parameter int unsigned ADDR_PW  = 5,
  parameter int unsigned ADDR_OVR = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SELW-1:0]  chan_sel,
  input  logic             ms_tick,
  input  logic             hold_all,
  input  logic             cfg_wr_en,
  input  logic [ADDRW-1:0] cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [NPORT-1:0] hpd_pull_low
);
  import hpd_pkg::*;
  localparam int CNTW = cnt_bits(DW, STEP_MS);

  logic             sw_event;
  logic             pulse_active;
  logic [CNTW-1:0]  remaining;
  logic [DW-1:0]    width_q;
  logic [NPORT-1:0] ovr_en, ovr_lvl;

  hpd_chan_watch #(.SELW(SELW)) watch_i (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .sw_event(sw_event)
  );

  hpd_regs #(
    .NPORT(NPORT), .ADDRW(ADDRW), .DW(DW), .PW_RESET(PW_RESET),
    .ADDR_PW(ADDR_PW), .ADDR_OVR(ADDR_OVR)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .addr(cfg_addr),
    .wdata(cfg_wdata), .width_q(width_q), .ovr_en(ovr_en), .ovr_lvl(ovr_lvl)
  );

  hpd_pulse_timer #(.DW(DW), .STEP_MS(STEP_MS), .CNTW(CNTW)) timer_i (
    .clk(clk), .rst_n(rst_n), .start(sw_event), .width(width_q),
    .ms_tick(ms_tick), .active(pulse_active), .remaining(remaining)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic auto_low;
    assign auto_low = ovr_en[p] ? ~ovr_lvl[p] : pulse_active;
    assign hpd_pull_low[p] = hold_all | auto_low;
  end
endmodule

// File: rtl/hpd_pulse_ctrl_chk.sv
module hpd_pulse_ctrl_chk #(
  parameter int NPORT = 4,
  parameter int DW    = 8,
  parameter int CNTW  = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sw_event,
  input logic             ms_tick,
  input logic             hold_all,
  input logic             pulse_active,
  input logic [CNTW-1:0]  remaining,
  input logic [DW-1:0]    width_q,
  input logic [NPORT-1:0] ovr_en,
  input logic [NPORT-1:0] hpd_pull_low
);
  a_r2_switch_starts: assert property (@(posedge clk) disable iff (!rst_n)
    sw_event && (width_q != '0) |=> pulse_active);

  a_r6_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
    sw_event && (width_q == '0) |=> !pulse_active);

  a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_active && ms_tick && !sw_event && (remaining > CNTW'(1))
    |=> pulse_active && (remaining == $past(remaining) - CNTW'(1)));

  a_r3_ends: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_active && ms_tick && !sw_event && (remaining == CNTW'(1))
    |=> !pulse_active);

  a_r3_no_tick_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_tick && !sw_event |=> $stable(remaining) && $stable(pulse_active));

  a_r8_hold_wins: assert property (@(posedge clk) disable iff (!rst_n)
    hold_all |-> (&hpd_pull_low));

  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse_active && !hold_all && (ovr_en == '0) |-> (hpd_pull_low == '0));
endmodule

bind hpd_pulse_ctrl hpd_pulse_ctrl_chk #(
  .NPORT(NPORT), .DW(DW), .CNTW(CNTW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .sw_event(sw_event), .ms_tick(ms_tick),
  .hold_all(hold_all), .pulse_active(pulse_active), .remaining(remaining),
  .width_q(width_q), .ovr_en(ovr_en), .hpd_pull_low(hpd_pull_low)
);

// File: tb/hpd_pulse_ctrl_tb_top.sv
module hpd_pulse_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] chan_sel = 2'd0;
  logic       ms_tick = 1'b0;
  logic       hold_all = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [3:0] cfg_addr = 4'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic [3:0] hpd_pull_low;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  hpd_pulse_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .chan_sel(chan_sel), .ms_tick(ms_tick),
    .hold_all(hold_all), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .hpd_pull_low(hpd_pull_low)
  );

  task automatic check(input string req, input logic [3:0] exp);
    checks++;
    if (hpd_pull_low !== exp) begin
      errors++;
      $display("FAIL %s: hpd_pull_low=%b expected=%b", req, hpd_pull_low, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic switch_to(input logic [1:0] c);
    chan_sel = c;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 reset released", 4'h0);
    ticks(130);
    check("R1 ticks without switch", 4'h0);
  endtask

  task automatic t_default_width;
    switch_to(2'd1);
    check("R2 switch pulls all low", 4'hF);
    idle(5);
    check("R3 no tick keeps low", 4'hF);
    ticks(119);
    check("R1 R3 default 120 ms still low at 119", 4'hF);
    ticks(1);
    check("R1 R3 default released at 120", 4'h0);
  endtask

  task automatic t_width_write;
    wr(4'h5, 8'd1);
    wr(4'h3, 8'd0);
    switch_to(2'd2);
    check("R4 R2 switch after width write", 4'hF);
    ticks(19);
    check("R4 other address ignored, low at 19", 4'hF);
    ticks(1);
    check("R4 R3 width 1 released at 20", 4'h0);
  endtask

  task automatic t_restart;
    switch_to(2'd3);
    ticks(10);
    switch_to(2'd0);
    ticks(19);
    check("R5 restart keeps low", 4'hF);
    ticks(1);
    check("R5 restart released at full length", 4'h0);
  endtask

  task automatic t_zero;
    wr(4'h5, 8'd0);
    switch_to(2'd1);
    check("R6 zero width no pulse", 4'h0);
    ticks(3);
    check("R6 zero width still released", 4'h0);
    wr(4'h5, 8'd1);
  endtask

  task automatic t_midwrite;
    switch_to(2'd2);
    ticks(5);
    wr(4'h5, 8'd2);
    ticks(14);
    check("R9 old length low at 19", 4'hF);
    ticks(1);
    check("R9 old length released at 20", 4'h0);
    switch_to(2'd3);
    ticks(39);
    check("R9 new length low at 39", 4'hF);
    ticks(1);
    check("R9 new length released at 40", 4'h0);
    wr(4'h5, 8'd1);
  endtask

  task automatic t_override;
    wr(4'h6, 8'h23);
    check("R7 override idle", 4'b0001);
    switch_to(2'd0);
    check("R7 override during pulse", 4'b1101);
    ticks(20);
    check("R7 override after pulse", 4'b0001);
    wr(4'h6, 8'h00);
    check("R7 R4 override cleared", 4'h0);
  endtask

  task automatic t_hold;
    wr(4'h6, 8'hFF);
    check("R7 all released by override", 4'h0);
    hold_all = 1'b1;
    #1;
    check("R8 hold forces low same cycle", 4'hF);
    idle(2);
    check("R8 hold persists", 4'hF);
    hold_all = 1'b0;
    #1;
    check("R8 hold release", 4'h0);
    wr(4'h6, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_default_width();
    t_width_write();
    t_restart();
    t_zero();
    t_midwrite();
    t_override();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule